// File: doc/BRIEF.md
# Multi-Context Register Address Generator

This block converts a register operand specifier from a multithreaded processing engine into a physical register-file location. Eight hardware contexts share one general-purpose register bank of 256 entries, a transfer register bank and a neighbour-register ring. Each request carries the active context number, an addressing mode, a bank select, a register number and a read/write flag. The block answers in the same cycle with the bank, the physical index, an error flag and a pointer-advance strobe.

In context-relative mode each context sees a private window of every bank. In absolute mode the register number is used as is, so any context can reach any entry of a bank. In indexed mode the request's own register number is ignored. The index comes from a pointer register instead: one pointer serves the transfer bank, and the neighbour ring has separate write (put) and read (get) pointers. The pointer that was used advances after each indexed access, and software can reload any pointer through a load port.

Encodings: mode 0 = context-relative, 1 = absolute, 2 = indexed, 3 = reserved. Bank 0 = general-purpose, 1 = transfer, 2 = neighbour, 3 = reserved. Load select 0 = transfer pointer, 1 = put pointer, 2 = get pointer, 3 = no pointer.

Top module: `regaddr_gen`

## Requirements
- R1: While reset is held, and after it is released, all three pointers are zero. With no request active (req_valid low), out_bank, out_index, out_err and out_step are all zero.
- R2: For a context-relative request to bank 0 with register number below 32, out_index = ctx*32 + reg. A register number of 32 or more sets out_err.
- R3: For a context-relative request to bank 1 or bank 2, the window per context is depth/8 entries (8 for the 64-entry transfer bank, 16 for the 128-entry neighbour ring). out_index = ctx*window + reg. A register number at or beyond the window sets out_err.
- R4: For an absolute request, out_index equals the register number for any context, provided the number is below the bank depth (256, 64, 128). Otherwise out_err is set.
- R5: An indexed request to bank 1 ignores the register number and returns the transfer pointer. The pointer then advances by one modulo 64 at the next clock edge.
- R6: An indexed request to bank 2 returns the put pointer for a write and the get pointer for a read. Only the pointer used advances, by one modulo 128.
- R7: A load with ld_valid high writes ld_value modulo the target pointer's depth into the pointer chosen by ld_sel, and the new value is visible from the next cycle. If the same pointer is also being stepped in that cycle, the load wins. ld_sel 3 changes nothing.
- R8: The following combinations set out_err, force out_index to 0, give no out_step and change no pointer: indexed mode on bank 0, bank 3 in any mode, and mode 3.
- R9: out_step is high exactly when a valid indexed request addresses bank 1 or bank 2.
- R10: On a valid request, out_bank repeats req_bank, including requests that set out_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | CTX_W (3) | Active context number |
| req_mode | input | 2 | Addressing mode (0 relative, 1 absolute, 2 indexed) |
| req_bank | input | 2 | Bank (0 general, 1 transfer, 2 neighbour) |
| req_reg | input | REG_W (8) | Register number from the operand |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| ld_valid | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load (0 transfer, 1 put, 2 get, 3 none) |
| ld_value | input | REG_W (8) | Value to load, reduced modulo the pointer depth |
| out_bank | output | 2 | Bank of the resolved access |
| out_index | output | REG_W (8) | Physical register index |
| out_err | output | 1 | Invalid mode/bank/number combination |
| out_step | output | 1 | An index pointer advances at the next edge |

## Verification
The assertions take for granted that the bank depths are powers of two and that no depth exceeds the range of the register-number field. Under that assumption a pointer can always be compared with a depth-reduced value. They also take for granted that reset is held for at least one clock edge before any load or request is checked. The stimulus keeps to the default depths and holds reset for two edges. It then drives every field over its full encoded range, including reserved modes and banks and out-of-range register numbers, because the block must handle any input value.

// File: rtl/regaddr_pkg.sv
package regaddr_pkg;

  typedef enum logic [1:0] {
    AM_REL = 2'd0,
    AM_ABS = 2'd1,
    AM_IDX = 2'd2,
    AM_RSV = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    BK_GPR  = 2'd0,
    BK_XFER = 2'd1,
    BK_NBR  = 2'd2,
    BK_RSV  = 2'd3
  } bank_e;

  // pointer slots, also the load-select code
  localparam int PTR_XIDX = 0;
  localparam int PTR_PUT  = 1;
  localparam int PTR_GET  = 2;
  localparam int NUM_PTR  = 3;

endpackage

// File: rtl/regaddr_ptr.sv
module regaddr_ptr #(
  parameter int DEPTH = 64,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [REG_W-1:0] ld_val,
  output logic [REG_W-1:0] ptr
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] ptr_q;
  logic          step_taken;   // increment actually applied
  logic          wrap_evt;     // increment rolls over to zero

  function automatic logic [PW-1:0] ptr_advance(input logic [PW-1:0] p);
    return p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_reduce(input logic [REG_W-1:0] v);
    return v[PW-1:0];
  endfunction

  assign step_taken = step && !load;
  assign wrap_evt   = step_taken && (ptr_q == PW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          ptr_q <= '0;
    else if (load)       ptr_q <= ptr_reduce(ld_val);
    else if (step_taken) ptr_q <= ptr_advance(ptr_q);
  end

  assign ptr = REG_W'(ptr_q);

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < DEPTH);                                                     // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> int'(ptr) == (int'($past(ptr)) + 1) % DEPTH);            // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ptr == '0);                                                // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> int'(ptr) == int'($past(ld_val)) % DEPTH);                     // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr));                                     // R8

endmodule

// File: rtl/regaddr_map.sv
module regaddr_map
  import regaddr_pkg::*;
#(
  parameter int CTX_W      = 3,
  parameter int REG_W      = 8,
  parameter int GPR_DEPTH  = 256,
  parameter int XFER_DEPTH = 64,
  parameter int NBR_DEPTH  = 128
) (
  input  logic             valid,
  input  logic [CTX_W-1:0] ctx,
  input  logic [1:0]       mode,
  input  logic [1:0]       bank,
  input  logic [REG_W-1:0] regnum,
  input  logic             is_write,
  input  logic [REG_W-1:0] xidx_ptr,
  input  logic [REG_W-1:0] put_ptr,
  input  logic [REG_W-1:0] get_ptr,
  output logic [REG_W-1:0] phys,
  output logic             err,
  output logic [NUM_PTR-1:0] step_vec
);
  localparam int NUM_CTX = 1 << CTX_W;

  amode_e md;
  bank_e  bk;
  assign md = amode_e'(mode);
  assign bk = bank_e'(bank);

  function automatic int bank_depth(input bank_e b);
    case (b)
      BK_GPR:  return GPR_DEPTH;
      BK_XFER: return XFER_DEPTH;
      BK_NBR:  return NBR_DEPTH;
      default: return 0;
    endcase
  endfunction

  function automatic int window(input bank_e b);
    return bank_depth(b) / NUM_CTX;
  endfunction

  function automatic logic [REG_W-1:0] rel_index(input logic [CTX_W-1:0] c,
                                                  input logic [REG_W-1:0] r,
                                                  input int w);
    int t;
    t = int'(c) * w + int'(r);
    return REG_W'(t);
  endfunction

  always_comb begin
    phys     = '0;
    err      = 1'b0;
    step_vec = '0;
    if (valid) begin
      case (md)
        AM_REL: begin
          if (bk == BK_RSV || int'(regnum) >= window(bk)) err = 1'b1;
          else phys = rel_index(ctx, regnum, window(bk));
        end
        AM_ABS: begin
          if (bk == BK_RSV || int'(regnum) >= bank_depth(bk)) err = 1'b1;
          else phys = regnum;
        end
        AM_IDX: begin
          case (bk)
            BK_XFER: begin
              phys               = xidx_ptr;
              step_vec[PTR_XIDX] = 1'b1;
            end
            BK_NBR: begin
              if (is_write) begin
                phys              = put_ptr;
                step_vec[PTR_PUT] = 1'b1;
              end else begin
                phys              = get_ptr;
                step_vec[PTR_GET] = 1'b1;
              end
            end
            default: err = 1'b1;
          endcase
        end
        default: err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/regaddr_gen.sv
module regaddr_gen
  import regaddr_pkg::*;
#(
  parameter int CTX_W      = 3,
  parameter int REG_W      = 8,
  parameter int GPR_DEPTH  = 256,
  parameter int XFER_DEPTH = 64,
  parameter int NBR_DEPTH  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [1:0]       req_mode,
  input  logic [1:0]       req_bank,
  input  logic [REG_W-1:0] req_reg,
  input  logic             req_write,
  input  logic             ld_valid,
  input  logic [1:0]       ld_sel,
  input  logic [REG_W-1:0] ld_value,
  output logic [1:0]       out_bank,
  output logic [REG_W-1:0] out_index,
  output logic             out_err,
  output logic             out_step
);
  logic [REG_W-1:0]   ptr_q [NUM_PTR];
  logic [NUM_PTR-1:0] step_vec;
  logic [NUM_PTR-1:0] load_hit;   // decoded load strobes
  logic               idx_req;    // valid indexed request seen at the port

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    assign load_hit[g] = ld_valid && (ld_sel == 2'(g));
    regaddr_ptr #(
      .DEPTH (g == PTR_XIDX ? XFER_DEPTH : NBR_DEPTH),
      .REG_W (REG_W)
    ) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step_vec[g]),
      .load   (load_hit[g]),
      .ld_val (ld_value),
      .ptr    (ptr_q[g])
    );
  end

  regaddr_map #(
    .CTX_W      (CTX_W),
    .REG_W      (REG_W),
    .GPR_DEPTH  (GPR_DEPTH),
    .XFER_DEPTH (XFER_DEPTH),
    .NBR_DEPTH  (NBR_DEPTH)
  ) u_map (
    .valid    (req_valid),
    .ctx      (req_ctx),
    .mode     (req_mode),
    .bank     (req_bank),
    .regnum   (req_reg),
    .is_write (req_write),
    .xidx_ptr (ptr_q[PTR_XIDX]),
    .put_ptr  (ptr_q[PTR_PUT]),
    .get_ptr  (ptr_q[PTR_GET]),
    .phys     (out_index),
    .err      (out_err),
    .step_vec (step_vec)
  );

  assign out_step = |step_vec;
  assign out_bank = req_valid ? req_bank : 2'd0;
  assign idx_req  = req_valid && (req_mode == 2'd2);

  AST_ERR_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_index == '0);                                           // R8
  AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_step);                                                 // R8
  AST_STEP_ONE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_vec));                                                    // R6
  AST_STEP_IDX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_step |-> idx_req && (req_bank == 2'd1 || req_bank == 2'd2));        // R9
  AST_ABS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd1 && !out_err) |-> out_index == req_reg);  // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !out_err && !out_step && out_index == '0);               // R1

endmodule

// File: tb/regaddr_gen_tb.sv
`timescale 1ns/1ps
module regaddr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, ld_valid;
  logic [2:0] req_ctx;
  logic [1:0] req_mode, req_bank, ld_sel;
  logic [7:0] req_reg, ld_value;
  logic [1:0] out_bank;
  logic [7:0] out_index;
  logic       out_err, out_step;

  int n_chk = 0;
  int n_err = 0;
  int mx = 0, mp = 0, mg = 0;   // bench copies of the three pointers
  bit done = 0;

  always #2.5 clk = ~clk;

  regaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_mode(req_mode), .req_bank(req_bank), .req_reg(req_reg),
    .req_write(req_write), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_value(ld_value), .out_bank(out_bank), .out_index(out_index),
    .out_err(out_err), .out_step(out_step)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lim(int b);
    return (b == 0) ? 256 : (b == 1) ? 64 : (b == 2) ? 128 : 0;
  endfunction

  task automatic predict(output int eb, output int ei, output int ee,
                         output int es, output string rq);
    int b = int'(req_bank);
    int r = int'(req_reg);
    int span;
    eb = 0; ei = 0; ee = 0; es = 0; rq = "R1";
    if (!req_valid) return;
    eb = b;
    if (b == 3 || req_mode == 2'd3) begin ee = 1; rq = "R8"; return; end
    case (req_mode)
      2'd0: begin
        span = lim(b) / 8;
        rq = (b == 0) ? "R2" : "R3";
        if (r >= span) ee = 1; else ei = int'(req_ctx) * span + r;
      end
      2'd1: begin
        rq = "R4";
        if (r >= lim(b)) ee = 1; else ei = r;
      end
      default: begin
        if (b == 0) begin ee = 1; rq = "R8"; end
        else if (b == 1) begin ei = mx; es = 1; rq = "R5"; end
        else begin ei = req_write ? mp : mg; es = 1; rq = "R6"; end
      end
    endcase
  endtask

  // Drive at the falling edge, check mid-cycle, update the model after the rising edge.
  task automatic cycle(bit v, int c, int m, int b, int r, bit w,
                       bit lv, int ls, int lval);
    int eb, ei, ee, es;
    string rq;
    req_valid = v; req_ctx = 3'(c); req_mode = 2'(m); req_bank = 2'(b);
    req_reg = 8'(r); req_write = w; ld_valid = lv; ld_sel = 2'(ls);
    ld_value = 8'(lval);
    #1;
    predict(eb, ei, ee, es, rq);
    check("R10", "bank", int'(out_bank), eb);
    check(rq, "index", int'(out_index), ei);
    check(rq, "err", int'(out_err), ee);
    check("R9", "step", int'(out_step), es);
    @(posedge clk);
    if (es == 1 && b == 1) mx = (mx + 1) % 64;
    if (es == 1 && b == 2 && w) mp = (mp + 1) % 128;
    if (es == 1 && b == 2 && !w) mg = (mg + 1) % 128;
    if (lv && ls == 0) mx = lval % 64;   // R7 load beats step
    if (lv && ls == 1) mp = lval % 128;
    if (lv && ls == 2) mg = lval % 128;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_ctx = 0; req_mode = 0; req_bank = 0; req_reg = 0;
    req_write = 0; ld_valid = 0; ld_sel = 3; ld_value = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", "idx_in_reset", int'(out_index), 0);
    check("R1", "err_in_reset", int'(out_err), 0);
    rst_n = 1'b1;
    cycle(0, 5, 1, 1, 9, 0, 0, 3, 0);     // R1 idle
    cycle(1, 4, 2, 1, 77, 0, 0, 3, 0);    // R1/R5 pointer starts at 0
    // R2 relative GPR
    cycle(1, 7, 0, 0, 31, 0, 0, 3, 0);
    cycle(1, 2, 0, 0, 32, 1, 0, 3, 0);
    // R3 relative windows
    cycle(1, 7, 0, 1, 7, 0, 0, 3, 0);
    cycle(1, 3, 0, 1, 8, 0, 0, 3, 0);
    cycle(1, 5, 0, 2, 15, 1, 0, 3, 0);
    // R4 absolute from any context
    cycle(1, 3, 1, 0, 255, 0, 0, 3, 0);
    cycle(1, 6, 1, 1, 64, 0, 0, 3, 0);
    cycle(1, 0, 1, 2, 127, 1, 0, 3, 0);
    // R8 invalid combos
    cycle(1, 1, 2, 0, 5, 0, 0, 3, 0);
    cycle(1, 1, 3, 1, 5, 0, 0, 3, 0);
    cycle(1, 1, 0, 3, 5, 0, 0, 3, 0);
    // R7 load modulo, then R5 wrap
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 200);
    cycle(1, 0, 2, 1, 0, 0, 0, 3, 0);
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 63);
    cycle(1, 0, 2, 1, 0, 0, 0, 3, 0);
    cycle(1, 0, 2, 1, 0, 0, 0, 3, 0);
    // R7 load and step on the same pointer
    cycle(1, 0, 2, 1, 0, 0, 1, 0, 20);
    cycle(1, 0, 2, 1, 0, 0, 0, 3, 0);
    // R6 put/get separation and wrap
    cycle(0, 0, 0, 0, 0, 0, 1, 1, 127);
    cycle(1, 0, 2, 2, 3, 1, 0, 3, 0);
    cycle(1, 0, 2, 2, 3, 1, 0, 3, 0);
    cycle(1, 0, 2, 2, 3, 0, 0, 3, 0);
    cycle(1, 0, 2, 2, 3, 0, 1, 2, 255);
    cycle(1, 0, 2, 2, 3, 0, 0, 3, 0);
    // random mix
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 8) != 0, $urandom % 8, $urandom % 4, $urandom % 4,
            ($urandom % 2) ? $urandom % 256 : $urandom % 40, $urandom % 2,
            ($urandom % 6) == 0, $urandom % 4, $urandom % 256);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule